// File: doc/BRIEF.md
# Flash Rewrite Sequencer with Erase Suspend

This block accepts program and block-erase commands from a CPU-side command port. It sequences them onto a flash-array handshake: an erase-enable or program-enable level plus a block index. The duration of each operation comes from an internal countdown. Erase and program lengths are parameters. The cells, their voltages and any lock storage sit outside the block.

A mode input selects how the CPU is treated.

- With the mode low, the CPU never stalls.
- With the mode high, a hold output stalls the CPU while a code block is being rewritten. Data blocks can still be rewritten with the CPU running. Commands aimed at the block that holds the rewrite routine are also refused.

A running erase can be parked under a master suspend enable, either by a software request or by an enabled interrupt. While the erase is parked, the array reads normally and programs are accepted. A resume command continues the erase from the count it had left. Status is reported as a ready flag and two sticky error flags.

Top module: `flash_rewrite_seq`

## Requirements
- R1: After reset the block reports ready, both error flags are 0, no erase is suspended, the CPU hold is low and both array enables are low.
- R2: An accepted program (cmdOp 1) holds ready low for PROG_CYCLES cycles with arrayProgEn high. An accepted erase (cmdOp 2) holds ready low for ERASE_CYCLES cycles with arrayEraseEn high. In both cases arrayBlock carries the commanded block, and ready returns high afterwards.
- R3: With rewriteMode low, cpuHold never rises, whatever the target block.
- R4: With rewriteMode high, cpuHold is high for the whole of a program or erase aimed at a code block (index below CODE_BLOCKS). It stays low for operations on data blocks.
- R5: With rewriteMode high, a program or erase whose block equals protBlock is refused. The refused command sets progErr or eraseErr respectively, ready stays high and neither array enable rises. With rewriteMode low the same command runs normally.
- R6: An erase is suspended only when suspendEnable is high. The trigger is then either swSuspendReq, or irqSuspendEnable together with irqPending. Without suspendEnable, the erase runs its full length.
- R7: With rewriteMode high, swSuspendReq suspends only an erase of a data block. The interrupt path suspends an erase of any block.
- R8: On suspend, the controller returns to read-array state on the next edge: ready high, eraseSuspended high, arrayEraseEn low. A program issued while suspended runs its full length, and the erase stays suspended afterwards.
- R9: A resume (cmdOp 3) restarts the erase with the count that remained at suspend. The active erase cycles before and after a suspend therefore add up to ERASE_CYCLES.
- R10: An erase command issued while an erase is suspended sets eraseErr and is otherwise ignored. The suspended erase and its remaining count are kept.
- R11: A clear-status command (cmdOp 4) clears both error flags.
- R12: Commands arriving while busy are ignored, as is a resume when no erase is suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, one cycle |
| cmdOp | input | 3 | 1 program, 2 erase, 3 resume, 4 clear status |
| cmdBlock | input | BLK_W | Target block of program or erase |
| rewriteMode | input | 1 | 0: CPU never held; 1: hold for code blocks, protection active |
| protBlock | input | BLK_W | Block holding the rewrite routine |
| suspendEnable | input | 1 | Master enable for erase suspend |
| swSuspendReq | input | 1 | Software suspend request |
| irqSuspendEnable | input | 1 | Allows an interrupt to suspend an erase |
| irqPending | input | 1 | Maskable interrupt pending |
| ready | output | 1 | High in read-array state |
| eraseErr | output | 1 | Sticky erase error |
| progErr | output | 1 | Sticky program error |
| eraseSuspended | output | 1 | An erase is parked |
| cpuHold | output | 1 | Stall request to the CPU |
| arrayEraseEn | output | 1 | Array erase in progress |
| arrayProgEn | output | 1 | Array program in progress |
| arrayBlock | output | BLK_W | Block the array operation targets |

## Verification
The bench sweeps the suspend point across every cycle of an erase, on both trigger paths, and checks that active erase cycles before and after resume add up to the full length. A design that reloaded the count on resume, or lost a cycle at the suspend edge, would show a wrong total. It walks every block in both modes. This catches a hold asserted for data blocks or in the free-running mode, and a protection check that leaks into the free-running mode or lets the array start. It also issues an erase into a parked erase and stray commands during a busy operation. A design that overwrote the parked count, or started a second operation, would misreport the later resume length.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_RESUME = 3'd3,
    OP_CLEAR  = 3'd4
  } cmd_op_e;

  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_ERASE = 2'd1,
    ST_PROG  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic startErase;
    logic startProg;
    logic eraseTick;
    logic progTick;
    logic setEraseErr;
    logic setProgErr;
    logic clearErr;
  } seq_strobe_t;
endpackage

// File: rtl/fseq_dpath.sv
module fseq_dpath
  import fseq_pkg::*;
#(
  parameter int BLK_W        = 3,
  parameter int ERASE_CYCLES = 64,
  parameter int PROG_CYCLES  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seq_strobe_t        strobes,
  input  logic [BLK_W-1:0]   cmdBlock,
  output logic               eraseLast,
  output logic               progLast,
  output logic [BLK_W-1:0]   eraseBlk,
  output logic [BLK_W-1:0]   progBlk,
  output logic               eraseErr,
  output logic               progErr
);
  localparam int EW = $clog2(ERASE_CYCLES + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  logic [EW-1:0] eraseRemain;
  logic [PW-1:0] progRemain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseRemain <= '0;
      eraseBlk    <= '0;
    end else if (strobes.startErase) begin
      eraseRemain <= EW'(ERASE_CYCLES);
      eraseBlk    <= cmdBlock;
    end else if (strobes.eraseTick) begin
      eraseRemain <= eraseRemain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progRemain <= '0;
      progBlk    <= '0;
    end else if (strobes.startProg) begin
      progRemain <= PW'(PROG_CYCLES);
      progBlk    <= cmdBlock;
    end else if (strobes.progTick) begin
      progRemain <= progRemain - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseErr <= 1'b0;
      progErr  <= 1'b0;
    end else if (strobes.clearErr) begin
      eraseErr <= 1'b0;
      progErr  <= 1'b0;
    end else begin
      if (strobes.setEraseErr) eraseErr <= 1'b1;
      if (strobes.setProgErr)  progErr  <= 1'b1;
    end
  end

  assign eraseLast = (eraseRemain == EW'(1));
  assign progLast  = (progRemain == PW'(1));

  // Parked erase count survives suspension, programs and rejected erases
  p_hold_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.eraseTick && !strobes.startErase) |=> $stable(eraseRemain));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (eraseErr && !strobes.clearErr) |=> eraseErr);

  p_prog_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (progErr && !strobes.clearErr) |=> progErr);
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
  import fseq_pkg::*;
#(
  parameter int BLK_W       = 3,
  parameter int CODE_BLOCKS = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [2:0]         cmdOp,
  input  logic [BLK_W-1:0]   cmdBlock,
  input  logic               rewriteMode,
  input  logic [BLK_W-1:0]   protBlock,
  input  logic               suspendEnable,
  input  logic               swSuspendReq,
  input  logic               irqSuspendEnable,
  input  logic               irqPending,
  input  logic               eraseLast,
  input  logic               progLast,
  input  logic [BLK_W-1:0]   eraseBlk,
  input  logic [BLK_W-1:0]   progBlk,
  output seq_strobe_t        strobes,
  output seq_state_e         state,
  output logic               suspended,
  output logic               cpuHold
);
  localparam logic [BLK_W:0] CODE_LIM = (BLK_W + 1)'(CODE_BLOCKS);

  function automatic logic isCode(input logic [BLK_W-1:0] blk);
    return ({1'b0, blk} < CODE_LIM);
  endfunction

  seq_state_e nextState;
  logic       nextSusp;
  logic       cmdProt;
  logic       swOk;
  logic       suspendHit;
  cmd_op_e    op;

  assign op         = cmd_op_e'(cmdOp);
  assign cmdProt    = rewriteMode && (cmdBlock == protBlock);
  assign swOk       = swSuspendReq && (!rewriteMode || !isCode(eraseBlk));
  assign suspendHit = suspendEnable && (swOk || (irqSuspendEnable && irqPending));

  always_comb begin
    strobes   = '0;
    nextState = state;
    nextSusp  = suspended;
    unique case (state)
      ST_READ: if (cmdValid) begin
        unique case (op)
          OP_PROG: begin
            if (cmdProt) strobes.setProgErr = 1'b1;
            else begin
              strobes.startProg = 1'b1;
              nextState         = ST_PROG;
            end
          end
          OP_ERASE: begin
            if (cmdProt || suspended) strobes.setEraseErr = 1'b1;
            else begin
              strobes.startErase = 1'b1;
              nextState          = ST_ERASE;
            end
          end
          OP_RESUME: if (suspended) begin
            nextSusp  = 1'b0;
            nextState = ST_ERASE;
          end
          OP_CLEAR: strobes.clearErr = 1'b1;
          default: ;
        endcase
      end
      ST_ERASE: begin
        strobes.eraseTick = 1'b1;
        if (eraseLast) nextState = ST_READ;
        else if (suspendHit) begin
          nextState = ST_READ;
          nextSusp  = 1'b1;
        end
      end
      ST_PROG: begin
        strobes.progTick = 1'b1;
        if (progLast) nextState = ST_READ;
      end
      default: nextState = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_READ;
      suspended <= 1'b0;
    end else begin
      state     <= nextState;
      suspended <= nextSusp;
    end
  end

  assign cpuHold = rewriteMode &&
                   (((state == ST_ERASE) && isCode(eraseBlk)) ||
                    ((state == ST_PROG) && isCode(progBlk)));

  p_no_susp_without_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ERASE) && !suspendEnable) |=> !suspended);

  p_reject_keeps_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_READ) && cmdValid && rewriteMode && (cmdBlock == protBlock) &&
     ((op == OP_PROG) || (op == OP_ERASE))) |=> (state == ST_READ));

  p_suspend_lands_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(suspended) |-> (state == ST_READ));

  p_busy_ignores_cmd_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PROG) && !progLast) |=> (state == ST_PROG));
endmodule

// File: rtl/flash_rewrite_seq.sv
module flash_rewrite_seq
  import fseq_pkg::*;
#(
  parameter int NUM_BLOCKS   = 8,
  parameter int CODE_BLOCKS  = 4,
  parameter int ERASE_CYCLES = 64,
  parameter int PROG_CYCLES  = 8,
  localparam int BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [BLK_W-1:0] cmdBlock,
  input  logic             rewriteMode,
  input  logic [BLK_W-1:0] protBlock,
  input  logic             suspendEnable,
  input  logic             swSuspendReq,
  input  logic             irqSuspendEnable,
  input  logic             irqPending,
  output logic             ready,
  output logic             eraseErr,
  output logic             progErr,
  output logic             eraseSuspended,
  output logic             cpuHold,
  output logic             arrayEraseEn,
  output logic             arrayProgEn,
  output logic [BLK_W-1:0] arrayBlock
);
  seq_strobe_t      strobes;
  seq_state_e       state;
  logic             eraseLast;
  logic             progLast;
  logic [BLK_W-1:0] eraseBlk;
  logic [BLK_W-1:0] progBlk;

  fseq_ctrl #(.BLK_W(BLK_W), .CODE_BLOCKS(CODE_BLOCKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .rewriteMode(rewriteMode), .protBlock(protBlock),
    .suspendEnable(suspendEnable), .swSuspendReq(swSuspendReq),
    .irqSuspendEnable(irqSuspendEnable), .irqPending(irqPending),
    .eraseLast(eraseLast), .progLast(progLast), .eraseBlk(eraseBlk),
    .progBlk(progBlk), .strobes(strobes), .state(state),
    .suspended(eraseSuspended), .cpuHold(cpuHold)
  );

  fseq_dpath #(.BLK_W(BLK_W), .ERASE_CYCLES(ERASE_CYCLES),
               .PROG_CYCLES(PROG_CYCLES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdBlock(cmdBlock),
    .eraseLast(eraseLast), .progLast(progLast), .eraseBlk(eraseBlk),
    .progBlk(progBlk), .eraseErr(eraseErr), .progErr(progErr)
  );

  assign ready        = (state == ST_READ);
  assign arrayEraseEn = (state == ST_ERASE);
  assign arrayProgEn  = (state == ST_PROG);
  assign arrayBlock   = (state == ST_PROG) ? progBlk : eraseBlk;

  p_hold_needs_mode_r3: assert property (@(posedge clk) disable iff (!rstN)
    cpuHold |-> (rewriteMode && !ready));

  p_one_array_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({arrayEraseEn, arrayProgEn}));
endmodule

// File: tb/flash_rewrite_seq_test.sv
`timescale 1ns/1ps
module flash_rewrite_seq_test;
  localparam int NB = 8;
  localparam int CB = 4;
  localparam int EC = 10;
  localparam int PC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [2:0] cmdBlock = 3'd0;
  logic rewriteMode = 1'b0;
  logic [2:0] protBlock = 3'd2;
  logic suspendEnable = 1'b1;
  logic swSuspendReq = 1'b0;
  logic irqSuspendEnable = 1'b0;
  logic irqPending = 1'b0;
  logic ready, eraseErr, progErr, eraseSuspended, cpuHold;
  logic arrayEraseEn, arrayProgEn;
  logic [2:0] arrayBlock;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_rewrite_seq #(.NUM_BLOCKS(NB), .CODE_BLOCKS(CB), .ERASE_CYCLES(EC),
                      .PROG_CYCLES(PC)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdBlock(cmdBlock), .rewriteMode(rewriteMode), .protBlock(protBlock),
    .suspendEnable(suspendEnable), .swSuspendReq(swSuspendReq),
    .irqSuspendEnable(irqSuspendEnable), .irqPending(irqPending),
    .ready(ready), .eraseErr(eraseErr), .progErr(progErr),
    .eraseSuspended(eraseSuspended), .cpuHold(cpuHold),
    .arrayEraseEn(arrayEraseEn), .arrayProgEn(arrayProgEn),
    .arrayBlock(arrayBlock)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one command across a single edge; returns at the following negedge
  task automatic issue(input int op, input int blk);
    @(negedge clk);
    cmdOp = 3'(op); cmdBlock = 3'(blk); cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
  endtask

  // Count busy cycles; optionally raise a suspend trigger in busy cycle suspAt
  task automatic runBusy(output int n, input int suspAt, input int path);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      if (n == suspAt) begin
        if (path == 0) swSuspendReq = 1'b1; else irqPending = 1'b1;
      end
      @(negedge clk);
      swSuspendReq = 1'b0; irqPending = 1'b0;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", ready, 1);
    check("R1 eraseErr", eraseErr, 0);
    check("R1 progErr", progErr, 0);
    check("R1 suspended", eraseSuspended, 0);
    check("R1 hold", cpuHold, 0);
    check("R1 array", {arrayEraseEn, arrayProgEn}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Sweep modes, ops and blocks: R2 R3 R4 R5 R11
    for (int m = 0; m < 2; m++) begin
      for (int isErase = 0; isErase < 2; isErase++) begin
        for (int b = 0; b < NB; b++) begin
          rewriteMode = m[0];
          issue(isErase ? 2 : 1, b);
          if (m == 1 && b == 2) begin
            check("R5 reject ready", ready, 1);
            check("R5 reject array", {arrayEraseEn, arrayProgEn}, 0);
            check("R5 reject flag", isErase ? eraseErr : progErr, 1);
            issue(4, 0);
            check("R11 clear", {eraseErr, progErr}, 0);
          end else begin
            check(m ? "R4 hold" : "R3 hold", cpuHold, (m == 1 && b < CB) ? 1 : 0);
            check("R2 enable", isErase ? arrayEraseEn : arrayProgEn, 1);
            check("R2 block", arrayBlock, b);
            runBusy(n, 0, 0);
            check("R2 length", n, isErase ? EC : PC);
            check("R2 ready", ready, 1);
            check("R5 no error", {eraseErr, progErr}, 0);
          end
        end
      end
    end

    // Software suspend sweep, free-running mode, data block: R6 R8 R9
    rewriteMode = 1'b0;
    for (int k = 1; k < EC; k++) begin
      issue(2, 5);
      runBusy(n, k, 0);
      check("R6 sw suspend point", n, k);
      check("R8 suspended", eraseSuspended, 1);
      check("R8 erase off", arrayEraseEn, 0);
      issue(3, 0);
      check("R9 resumed", arrayEraseEn, 1);
      runBusy(n, 0, 0);
      check("R9 remaining", n, EC - k);
      check("R9 clear susp", eraseSuspended, 0);
    end

    // Interrupt suspend sweep, hold mode, code block: R7 R9
    rewriteMode = 1'b1; irqSuspendEnable = 1'b1;
    for (int k = 1; k < EC; k++) begin
      issue(2, 1);
      runBusy(n, k, 1);
      check("R7 irq suspend code", n, k);
      check("R8 suspended", eraseSuspended, 1);
      issue(3, 0);
      check("R4 hold after resume", cpuHold, 1);
      runBusy(n, 0, 0);
      check("R9 remaining irq", n, EC - k);
    end
    irqSuspendEnable = 1'b0;

    // R7 sw request ignored on code block in hold mode, honored on data block
    issue(2, 1);
    runBusy(n, 3, 0);
    check("R7 sw code no suspend", n, EC);
    check("R7 not suspended", eraseSuspended, 0);
    issue(2, 6);
    runBusy(n, 3, 0);
    check("R7 sw data suspend", n, 3);
    issue(3, 0);
    runBusy(n, 0, 0);
    check("R7 data remaining", n, EC - 3);

    // R6 master enable off blocks both paths
    rewriteMode = 1'b0; suspendEnable = 1'b0; irqSuspendEnable = 1'b1;
    for (int p = 0; p < 2; p++) begin
      issue(2, 4);
      runBusy(n, 2, p);
      check("R6 no enable", n, EC);
      check("R6 not suspended", eraseSuspended, 0);
    end
    suspendEnable = 1'b1; irqSuspendEnable = 1'b0;

    // R8 program during suspend, R10 erase into suspended erase, R9 resume
    issue(2, 5);
    runBusy(n, 4, 0);
    issue(1, 6);
    check("R8 prog while suspended", arrayProgEn, 1);
    check("R8 prog block", arrayBlock, 6);
    runBusy(n, 0, 0);
    check("R8 prog length", n, PC);
    check("R8 still suspended", eraseSuspended, 1);
    issue(2, 3);
    check("R10 erase err", eraseErr, 1);
    check("R10 ready", ready, 1);
    check("R10 no erase", arrayEraseEn, 0);
    check("R10 still suspended", eraseSuspended, 1);
    issue(3, 0);
    check("R9 block kept", arrayBlock, 5);
    runBusy(n, 0, 0);
    check("R9 remaining after prog", n, EC - 4);
    check("R10 err sticky", eraseErr, 1);
    issue(4, 0);
    check("R11 clear erase err", eraseErr, 0);

    // R12 commands while busy ignored; resume without suspension ignored
    issue(2, 4);
    cmdValid = 1'b1; cmdOp = 3'd1; cmdBlock = 3'd7;
    repeat (3) @(negedge clk);
    cmdValid = 1'b0; cmdOp = 3'd0;
    check("R12 still erasing", arrayEraseEn, 1);
    runBusy(n, 0, 0);
    check("R12 length", n, EC - 3);
    check("R12 no prog", arrayProgEn, 0);
    check("R12 no error", {eraseErr, progErr}, 0);
    issue(3, 0);
    check("R12 stray resume", ready, 1);
    check("R12 stray resume array", arrayEraseEn, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule